// File: doc/BRIEF.md
# Zero-Cross Gated Gain Update Controller

This block decides the moment at which a newly requested gain code becomes the active gain of one audio channel. Software writes a requested gain, a 2-bit update mode and a 3-bit timeout select through simple write strobes. The active gain either follows the request one cycle later, or waits until the audio signal crosses zero, so the step in level is not heard as a click. A countdown timer bounds that wait: if no crossing comes in time, the update is forced when the count runs out.

Zero crossings come from the channel's signed sample stream by default. A build parameter can instead take them from an external one-cycle strobe. A new write that arrives while an update is still waiting is handled in one of two ways, chosen by the mode. It either replaces the waiting value, or first forces the waiting value through and then waits with the new one. In both cases the timer starts again. A master power-down bit, which is set after reset, and a per-channel power-down input hold the active gain still. Gain writes made while powered down are kept and are acted on once power is restored.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset the active gain is GAIN_RST (0 by default) and `applied` is 0. The mode register resets to 2'b01 (wait for a zero crossing, replace a waiting value), the timeout select resets to 0, and the master power-down bit resets to 1.
- R2: In mode 2'b00, and in mode 2'b11 which behaves the same way, a written gain becomes active on the second rising edge counting the write edge: one cycle after the write, with no wait for a zero crossing.
- R3: In modes 2'b01 and 2'b10, a requested gain that differs from the active gain becomes active on the edge where the first zero crossing after the write is detected.
- R4: If no zero crossing arrives, a waiting gain becomes active exactly 2^(tsel+4+BASE_SHIFT) clock cycles after the write edge, where tsel is the 3-bit timeout select (BASE_SHIFT defaults to 0).
- R5: In mode 2'b01, a write that arrives while an update is waiting discards the old waiting value, which never becomes active. It also restarts the timeout for the new value.
- R6: In mode 2'b10, a write that arrives while an update is waiting makes the old waiting value active on the write edge, with an `applied` pulse. It also restarts the timeout for the new value.
- R7: While the master power-down bit is 1, the active gain does not change, but gain writes are stored. Once the bit is cleared, the stored gain is applied according to the current mode.
- R8: While `chan_pd` is 1, the active gain is frozen and any waiting update and its timer are cleared. After release, a fresh full timeout starts for the stored gain.
- R9: A write of a value equal to the active gain, with nothing waiting, creates no waiting update and no `applied` pulse.
- R10: `applied` is high for exactly the cycles that follow an edge on which the active gain changed.
- R11: In the sample-stream variant, a zero crossing is a valid sample whose sign bit differs from the previous valid sample, or a valid sample equal to zero. Samples with `smp_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timeout count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gain_wr | input | 1 | Write strobe for the requested gain |
| gain_wdata | input | GAIN_W | Requested gain code |
| cfg_wr | input | 1 | Write strobe for mode and timeout select |
| cfg_mode | input | 2 | Mode: 00 immediate, 01 zero-cross with replace, 10 zero-cross with flush, 11 as 00 |
| cfg_tsel | input | 3 | Timeout select code |
| mpd_wr | input | 1 | Write strobe for the master power-down bit |
| mpd_wdata | input | 1 | New master power-down value |
| chan_pd | input | 1 | Channel power-down level |
| smp_valid | input | 1 | Sample valid |
| smp_data | input | SAMPLE_W | Signed audio sample |
| zc_strobe | input | 1 | External zero-crossing pulse (strobe variant only) |
| gain_act | output | GAIN_W | Active gain code |
| applied | output | 1 | One-cycle pulse after the active gain changes |

## Verification
On every cycle, the assertions check four things: that `applied` matches a change of the active gain, that power-down freezes the gain, that a crossing or an expired timer resolves a waiting update, and how a write made during a wait is treated in each of the two zero-cross modes. Only the bench scenarios can show the exact timeout length for different select codes, and that a discarded value never appears. They also show the behaviour that depends on history: how the sample sign is tracked, and that stored writes are restored after either kind of power-down.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
   typedef enum logic [1:0] {
      ZM_NOW   = 2'b00,
      ZM_DROP  = 2'b01,
      ZM_FLUSH = 2'b10,
      ZM_ALT   = 2'b11
   } zc_mode_e;

   localparam logic [1:0] MODE_RESET = 2'b01;
   localparam logic [2:0] TSEL_RESET = 3'd0;
   localparam int unsigned TMR_BASE_LOG2 = 4;
endpackage

// File: rtl/zc_cfg_regs.sv
module zc_cfg_regs
   import zc_gain_pkg::*;
#(
   parameter int unsigned GAIN_W = 8,
   parameter logic [GAIN_W-1:0] GAIN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gain_wr,
   input  logic [GAIN_W-1:0] gain_wdata,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_mode,
   input  logic [2:0]        cfg_tsel,
   input  logic              mpd_wr,
   input  logic              mpd_wdata,
   output logic [GAIN_W-1:0] req_gain,
   output zc_mode_e          mode,
   output logic [2:0]        tsel,
   output logic              master_pd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_gain  <= GAIN_RST;
         mode      <= zc_mode_e'(MODE_RESET);
         tsel      <= TSEL_RESET;
         master_pd <= 1'b1;
      end else begin
         if (gain_wr) req_gain <= gain_wdata;
         if (cfg_wr) begin
            mode <= zc_mode_e'(cfg_mode);
            tsel <= cfg_tsel;
         end
         if (mpd_wr) master_pd <= mpd_wdata;
      end
   end

endmodule

// File: rtl/zc_detect.sv
module zc_detect #(
   parameter int unsigned SAMPLE_W   = 16,
   parameter bit          USE_STROBE = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic                       zc_strobe,
   output logic                       zc_hit
);

   generate
      if (USE_STROBE) begin : g_strobe
         logic unused_smp;
         assign unused_smp = ^{smp_valid, smp_data, clk, rst_n};
         assign zc_hit = zc_strobe;
      end else begin : g_sample
         logic unused_strobe;
         logic prev_sign;
         logic have_prev;
         logic cur_sign;

         assign unused_strobe = zc_strobe;
         assign cur_sign = smp_data[SAMPLE_W-1];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_sign <= 1'b0;
               have_prev <= 1'b0;
            end else if (smp_valid) begin
               prev_sign <= cur_sign;
               have_prev <= 1'b1;
            end
         end

         assign zc_hit = smp_valid &&
                         ((smp_data == '0) || (have_prev && (cur_sign != prev_sign)));
      end
   endgenerate

endmodule

// File: rtl/zc_tmr.sv
module zc_tmr
   import zc_gain_pkg::*;
#(
   parameter int unsigned BASE_SHIFT = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       load,
   input  logic       run,
   input  logic [2:0] code,
   output logic       done
);

   localparam int unsigned CNT_W = TMR_BASE_LOG2 + 8 + BASE_SHIFT;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = (CNT_W'(1) << (int'(code) + TMR_BASE_LOG2 + BASE_SHIFT)) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clear)           cnt <= '0;
      else if (load)            cnt <= limit;
      else if (run && cnt != 0) cnt <= cnt - CNT_W'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
   import zc_gain_pkg::*;
#(
   parameter int unsigned GAIN_W     = 8,
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned BASE_SHIFT = 0,
   parameter bit          USE_STROBE = 1'b0,
   parameter logic [GAIN_W-1:0] GAIN_RST = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       gain_wr,
   input  logic [GAIN_W-1:0]          gain_wdata,
   input  logic                       cfg_wr,
   input  logic [1:0]                 cfg_mode,
   input  logic [2:0]                 cfg_tsel,
   input  logic                       mpd_wr,
   input  logic                       mpd_wdata,
   input  logic                       chan_pd,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic                       zc_strobe,
   output logic [GAIN_W-1:0]          gain_act,
   output logic                       applied
);

   generate
      if (GAIN_W < 1 || GAIN_W > 32) begin : g_bad_gain_w
         initial $fatal(1, "zc_gain_ctrl: GAIN_W out of range");
      end
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         initial $fatal(1, "zc_gain_ctrl: SAMPLE_W must be at least 2");
      end
      if (BASE_SHIFT > 12) begin : g_bad_shift
         initial $fatal(1, "zc_gain_ctrl: BASE_SHIFT too large");
      end
   endgenerate

   logic [GAIN_W-1:0] req_gain;
   zc_mode_e          mode;
   logic [2:0]        tsel;
   logic              master_pd;
   logic              zc_hit;
   logic              tmr_done;
   logic              halt;
   logic              immediate;
   logic              pend_q, pend_d;
   logic [GAIN_W-1:0] act_d;
   logic [GAIN_W-1:0] base;
   logic              tmr_load;

   zc_cfg_regs #(.GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .gain_wr(gain_wr), .gain_wdata(gain_wdata),
      .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel),
      .mpd_wr(mpd_wr), .mpd_wdata(mpd_wdata),
      .req_gain(req_gain), .mode(mode), .tsel(tsel), .master_pd(master_pd)
   );

   zc_detect #(.SAMPLE_W(SAMPLE_W), .USE_STROBE(USE_STROBE)) u_zc (
      .clk(clk), .rst_n(rst_n),
      .smp_valid(smp_valid), .smp_data(smp_data), .zc_strobe(zc_strobe),
      .zc_hit(zc_hit)
   );

   zc_tmr #(.BASE_SHIFT(BASE_SHIFT)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .clear(halt), .load(tmr_load), .run(pend_q), .code(tsel),
      .done(tmr_done)
   );

   assign halt      = master_pd | chan_pd;
   assign immediate = (mode == ZM_NOW) || (mode == ZM_ALT);

   always_comb begin
      act_d    = gain_act;
      pend_d   = pend_q;
      tmr_load = 1'b0;
      base     = gain_act;
      if (halt) begin
         pend_d = 1'b0;
      end else if (immediate) begin
         pend_d = 1'b0;
         if (req_gain != gain_act) act_d = req_gain;
      end else if (gain_wr) begin
         if (pend_q && mode == ZM_FLUSH) begin
            act_d = req_gain;
            base  = req_gain;
         end
         if (gain_wdata != base) begin
            pend_d   = 1'b1;
            tmr_load = 1'b1;
         end else begin
            pend_d = 1'b0;
         end
      end else if (pend_q) begin
         if (zc_hit || tmr_done) begin
            act_d  = req_gain;
            pend_d = 1'b0;
         end
      end else if (req_gain != gain_act) begin
         pend_d   = 1'b1;
         tmr_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_act <= GAIN_RST;
         pend_q   <= 1'b0;
         applied  <= 1'b0;
      end else begin
         gain_act <= act_d;
         pend_q   <= pend_d;
         applied  <= (act_d != gain_act);
      end
   end

endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk
   import zc_gain_pkg::*;
#(
   parameter int unsigned GAIN_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gain_wr,
   input logic [GAIN_W-1:0] gain_act,
   input logic              applied,
   input logic [GAIN_W-1:0] req_gain,
   input logic              pend,
   input logic              halt,
   input logic              tmr_done,
   input logic              zc_hit,
   input zc_mode_e          mode
);

   // R10: a change of the active gain is always flagged
   p_change_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gain_act) |-> applied);

   // R10: the flag never fires without a change
   p_flag_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      applied |-> !$stable(gain_act));

   // R7, R8: power-down freezes the active gain
   p_pd_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(gain_act));

   // R3, R4: a crossing or an expired timer resolves a waiting update
   p_resolve_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !halt && !gain_wr && (zc_hit || tmr_done))
         |=> (applied && gain_act == $past(req_gain)));

   // R5: replace mode keeps the active gain on a write made during a wait
   p_drop_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !halt && gain_wr && mode == ZM_DROP) |=> $stable(gain_act));

   // R6: flush mode forces the waiting value on a write made during a wait
   p_flush_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !halt && gain_wr && mode == ZM_FLUSH)
         |=> (applied && gain_act == $past(req_gain)));

endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .gain_act(gain_act),
   .applied(applied), .req_gain(req_gain), .pend(pend_q), .halt(halt),
   .tmr_done(tmr_done), .zc_hit(zc_hit), .mode(mode)
);

// File: tb/zc_gain_ctrl_tb.sv
`timescale 1ns/100ps
module zc_gain_ctrl_tb;

   localparam int GW = 8;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gain_wr = 1'b0;
   logic [GW-1:0] gain_wdata = '0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [2:0] cfg_tsel = 3'd0;
   logic mpd_wr = 1'b0;
   logic mpd_wdata = 1'b0;
   logic chan_pd = 1'b0;
   logic smp_valid = 1'b0;
   logic signed [SW-1:0] smp_data = '0;
   logic zc_strobe = 1'b0;
   logic [GW-1:0] gain_act;
   logic applied;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   zc_gain_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .gain_wdata(gain_wdata),
      .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel),
      .mpd_wr(mpd_wr), .mpd_wdata(mpd_wdata), .chan_pd(chan_pd),
      .smp_valid(smp_valid), .smp_data(smp_data), .zc_strobe(zc_strobe),
      .gain_act(gain_act), .applied(applied)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_gain(input string req, input int exp);
      check(int'(gain_act) == exp, req, int'(gain_act), exp);
   endtask

   task automatic chk_pulse(input string req, input bit exp);
      check(applied == exp, req, int'(applied), int'(exp));
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_gain(input int v);
      gain_wr = 1'b1; gain_wdata = GW'(v);
      tick();
      gain_wr = 1'b0;
   endtask

   task automatic wr_cfg(input logic [1:0] m, input logic [2:0] t);
      cfg_wr = 1'b1; cfg_mode = m; cfg_tsel = t;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic wr_mpd(input bit b);
      mpd_wr = 1'b1; mpd_wdata = b;
      tick();
      mpd_wr = 1'b0;
   endtask

   task automatic smp(input int v, input bit vld);
      smp_valid = vld; smp_data = SW'(v);
      tick();
      smp_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk_gain("R1 reset gain", 0);
      chk_pulse("R1 reset applied", 1'b0);
   endtask

   task automatic t_master_pd();
      wr_gain(8'h05);
      smp(0, 1'b1);
      chk_gain("R7 held in master power-down", 0);
      repeat (3) tick();
      chk_gain("R7 still held", 0);
      wr_mpd(1'b0);
      tick();
      chk_gain("R1 default mode waits for crossing", 0);
      smp(0, 1'b1);
      chk_gain("R7 stored gain applied after power-up (R3)", 8'h05);
      chk_pulse("R10 pulse on apply", 1'b1);
      tick();
      chk_pulse("R10 pulse lasts one cycle", 1'b0);
   endtask

   task automatic t_immediate();
      wr_cfg(2'b00, 3'd0);
      wr_gain(8'h20);
      chk_gain("R2 not yet on write edge", 8'h05);
      tick();
      chk_gain("R2 mode 00 applied next cycle", 8'h20);
      chk_pulse("R10 pulse mode 00", 1'b1);
      tick();
      chk_pulse("R10 pulse cleared", 1'b0);
      wr_cfg(2'b11, 3'd0);
      wr_gain(8'h21);
      tick();
      chk_gain("R2 mode 11 acts as 00", 8'h21);
   endtask

   task automatic t_same_value();
      int pulses = 0;
      wr_cfg(2'b01, 3'd0);
      wr_gain(8'h21);
      for (int i = 0; i < 24; i++) begin
         if (applied) pulses++;
         tick();
      end
      check(pulses == 0, "R9 same value gives no pulse", pulses, 0);
      chk_gain("R9 gain unchanged", 8'h21);
   endtask

   task automatic t_timeout();
      wr_gain(8'h40);
      repeat (15) tick();
      chk_gain("R4 code 0 not expired at 15", 8'h21);
      tick();
      chk_gain("R4 code 0 expired at 16", 8'h40);
      chk_pulse("R4 pulse on timeout", 1'b1);
      wr_cfg(2'b01, 3'd2);
      wr_gain(8'h41);
      repeat (63) tick();
      chk_gain("R4 code 2 not expired at 63", 8'h40);
      tick();
      chk_gain("R4 code 2 expired at 64", 8'h41);
   endtask

   task automatic t_drop();
      wr_cfg(2'b01, 3'd0);
      wr_gain(8'h50);
      repeat (9) tick();
      wr_gain(8'h51);
      chk_gain("R5 rewrite keeps active gain", 8'h41);
      repeat (15) tick();
      chk_gain("R5 timer restarted, old value discarded", 8'h41);
      tick();
      chk_gain("R5 new value after fresh timeout", 8'h51);
   endtask

   task automatic t_flush();
      wr_cfg(2'b10, 3'd0);
      wr_gain(8'h60);
      repeat (4) tick();
      wr_gain(8'h61);
      chk_gain("R6 old waiting value forced", 8'h60);
      chk_pulse("R6 pulse on forced apply", 1'b1);
      repeat (15) tick();
      chk_gain("R6 new value still waiting", 8'h60);
      tick();
      chk_gain("R6 new value after fresh timeout", 8'h61);
   endtask

   task automatic t_chan_pd();
      wr_cfg(2'b01, 3'd0);
      wr_gain(8'h70);
      repeat (10) tick();
      chan_pd = 1'b1;
      repeat (10) tick();
      smp(0, 1'b1);
      chk_gain("R8 frozen under channel power-down", 8'h61);
      chan_pd = 1'b0;
      repeat (16) tick();
      chk_gain("R8 timer cleared, full wait after release", 8'h61);
      tick();
      chk_gain("R8 stored gain applied after release", 8'h70);
   endtask

   task automatic t_zc_detect();
      wr_cfg(2'b01, 3'd7);
      smp(100, 1'b1);
      wr_gain(8'h10);
      smp(200, 1'b1);
      chk_gain("R11 same sign is no crossing", 8'h70);
      smp(-5, 1'b0);
      chk_gain("R11 invalid sample ignored", 8'h70);
      smp(-5, 1'b1);
      chk_gain("R11 sign change applies (R3)", 8'h10);
      smp(5, 1'b1);
      chk_pulse("R11 crossing with nothing waiting", 1'b0);
      wr_gain(8'h11);
      smp(0, 1'b1);
      chk_gain("R11 zero sample is a crossing", 8'h11);
      smp(-3, 1'b1);
      wr_gain(8'h12);
      smp(-7, 1'b1);
      chk_gain("R11 negative to negative no crossing", 8'h11);
      smp(9, 1'b1);
      chk_gain("R11 negative to positive applies", 8'h12);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_master_pd();
      t_immediate();
      t_same_value();
      t_timeout();
      t_drop();
      t_flush();
      t_chan_pd();
      t_zc_detect();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule